// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the horizontal and vertical timing for a character-based video controller. It advances once per CPU-rate clock enable. It keeps a position-within-line counter and a line-within-frame counter. From these it derives the blanking and sync levels and the line-start and frame-start strobes. A mode input picks the 50 Hz or the 60 Hz standard. That choice sets the line length, the frame length and the point in the line where the software-visible raster value changes.

Software sees a small register window. The raster register holds the current line number halved, so it counts pairs of lines. A companion register carries the odd/even bit of the line in its top bit. A control register carries the interlace enable in bit 7. In 60 Hz mode, interlace makes every second frame one line longer. The visible raster value does not follow the line counter directly. It is sampled at a fixed cycle of each line: early in the blanking interval in 50 Hz mode, and near mid-line in 60 Hz mode.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, hcount, vcount, all three readable registers, line_start and frame_start are zero, and interlace is off.
- R2: In 50 Hz mode (mode_60 = 0), hcount counts 0..70 on enabled cycles and then wraps to 0. line_start is high for the one clock after the enabled edge that wraps it.
- R3: In 60 Hz mode (mode_60 = 1), hcount counts 0..64 and then wraps to 0, with the same line_start pulse.
- R4: In 50 Hz mode a frame has 312 lines (vcount 0..311). On the wrap from line 311, cycle 70, to line 0, cycle 0, frame_start is high for exactly one clock.
- R5: In 60 Hz mode with interlace off, a frame has 261 lines (vcount 0..260), with the same frame_start pulse.
- R6: In 60 Hz mode with interlace on, frames alternate between 261 and 262 lines. The first frame after interlace is enabled from reset has 261 lines, and the next has 262.
- R7: Reading address 2 returns the sampled line number shifted right by one. In 50 Hz mode the sample is taken at the enabled edge where hcount becomes 4. It changes at no other time.
- R8: In 60 Hz mode the raster register at address 2 is sampled at the enabled edge where hcount becomes 32.
- R9: Reading address 1 returns the low bit of the sampled line number in bit 7. Bits 6..0 read as zero.
- R10: A write to address 0 stores the byte, and a read of address 0 returns it. Bit 7 of that byte is the interlace enable.
- R11: hblank is high while hcount is 0..11. hsync is high while hcount is 2..6. vsync is high while vcount is 0..2.
- R12: When cyc_en is low, hcount, vcount and the raster registers hold their values, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | CPU-cycle enable; advances the timing by one cycle |
| mode_60 | input | 1 | 0 selects 50 Hz timing, 1 selects 60 Hz timing |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 line parity, 2 raster |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hcount | output | 7 | Cycle within the current line |
| vcount | output | 9 | Line within the current frame |
| hblank | output | 1 | Horizontal blanking level |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| line_start | output | 1 | One-clock pulse after a line wrap |
| frame_start | output | 1 | One-clock pulse after a frame wrap |

## Verification
The bench targets the exact edge at which the raster register steps, in both modes. A design that used the wrong sample point, or one that simply mirrored vcount, would show the new value one or more cycles early or late, or at a line wrap. It crosses frame ends in each mode and in both interlace fields. A wrong line count or a missing field toggle would put vcount and frame_start out of step with the model from that point on. It also inserts idle enable gaps. A counter that advanced on plain clock edges would drift away from the expected cycle position.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int DEF_CYC_50       = 71;
  localparam int DEF_CYC_60       = 65;
  localparam int DEF_LINES_50     = 312;
  localparam int DEF_LINES_60     = 261;
  localparam int DEF_STEP_50      = 4;
  localparam int DEF_STEP_60      = 32;
  localparam int DEF_HBLANK_LEN   = 12;
  localparam int DEF_HSYNC_START  = 2;
  localparam int DEF_HSYNC_LEN    = 5;
  localparam int DEF_VSYNC_LINES  = 3;
  localparam int DEF_DATA_W       = 8;
  localparam int DEF_SYNC_STAGES  = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PARITY = 2'd1,
    REG_RASTER = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int CYC_50 = raster_pkg::DEF_CYC_50,
  parameter int CYC_60 = raster_pkg::DEF_CYC_60,
  parameter int H_W    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_en,
  input  logic           mode_60,
  output logic [H_W-1:0] hcount,
  output logic [H_W-1:0] hcount_nxt,
  output logic           line_end
);
  localparam logic [H_W-1:0] LAST_50 = H_W'(CYC_50 - 1);
  localparam logic [H_W-1:0] LAST_60 = H_W'(CYC_60 - 1);

  logic [H_W-1:0] hcount_q;
  logic [H_W-1:0] last_h;

  always_comb begin
    last_h   = mode_60 ? LAST_60 : LAST_50;
    line_end = cyc_en && (hcount_q >= last_h);
    if (!cyc_en)      hcount_nxt = hcount_q;
    else if (line_end) hcount_nxt = '0;
    else              hcount_nxt = hcount_q + H_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcount_q <= '0;
    else        hcount_q <= hcount_nxt;
  end

  assign hcount = hcount_q;
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
  parameter int LINES_50 = raster_pkg::DEF_LINES_50,
  parameter int LINES_60 = raster_pkg::DEF_LINES_60,
  parameter int V_W      = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_end,
  input  logic           mode_60,
  input  logic           ilace,
  output logic [V_W-1:0] vcount,
  output logic           frame_end
);
  localparam logic [V_W-1:0] LAST_50 = V_W'(LINES_50 - 1);
  localparam logic [V_W-1:0] LAST_60 = V_W'(LINES_60 - 1);

  logic [V_W-1:0] vcount_q, vcount_d;
  logic           field_q, field_d;
  logic [V_W-1:0] last_v;

  always_comb begin
    last_v    = mode_60 ? (LAST_60 + V_W'(ilace & field_q)) : LAST_50;
    frame_end = line_end && (vcount_q >= last_v);
    vcount_d  = vcount_q;
    field_d   = field_q;
    if (line_end) begin
      if (frame_end) begin
        vcount_d = '0;
        field_d  = ilace & ~field_q;
      end else begin
        vcount_d = vcount_q + V_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcount_q <= '0;
      field_q  <= 1'b0;
    end else begin
      vcount_q <= vcount_d;
      field_q  <= field_d;
    end
  end

  assign vcount = vcount_q;
endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int STEP_50 = DEF_STEP_50,
  parameter int STEP_60 = DEF_STEP_60,
  parameter int H_W     = 7,
  parameter int V_W     = 9,
  parameter int DATA_W  = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cyc_en,
  input  logic              mode_60,
  input  logic [H_W-1:0]    hcount_nxt,
  input  logic [V_W-1:0]    vcount,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ilace
);
  localparam logic [H_W-1:0] STEP_H50 = H_W'(STEP_50);
  localparam logic [H_W-1:0] STEP_H60 = H_W'(STEP_60);

  logic [V_W-1:0]    vis_q, vis_d;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              step_hit;
  reg_sel_e          sel;

  always_comb begin
    step_hit = cyc_en && (hcount_nxt == (mode_60 ? STEP_H60 : STEP_H50));
    vis_d    = step_hit ? vcount : vis_q;
    sel      = reg_sel_e'(reg_addr);
    ctrl_d   = (reg_we && sel == REG_CTRL) ? reg_wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q  <= '0;
      ctrl_q <= '0;
    end else begin
      vis_q  <= vis_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:   reg_rdata = ctrl_q;
      REG_PARITY: reg_rdata = {vis_q[0], (DATA_W-1)'(0)};
      REG_RASTER: reg_rdata = DATA_W'(vis_q >> 1);
      default:    reg_rdata = '0;
    endcase
  end

  assign ilace = ctrl_q[DATA_W-1];
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int CYC_50      = DEF_CYC_50,
  parameter int CYC_60      = DEF_CYC_60,
  parameter int LINES_50    = DEF_LINES_50,
  parameter int LINES_60    = DEF_LINES_60,
  parameter int STEP_50     = DEF_STEP_50,
  parameter int STEP_60     = DEF_STEP_60,
  parameter int HBLANK_LEN  = DEF_HBLANK_LEN,
  parameter int HSYNC_START = DEF_HSYNC_START,
  parameter int HSYNC_LEN   = DEF_HSYNC_LEN,
  parameter int VSYNC_LINES = DEF_VSYNC_LINES,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int H_W        = $clog2(max2(CYC_50, CYC_60)),
  localparam int V_W        = $clog2(max2(LINES_50, LINES_60 + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              mode_60,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [H_W-1:0]    hcount,
  output logic [V_W-1:0]    vcount,
  output logic              hblank,
  output logic              hsync,
  output logic              vsync,
  output logic              line_start,
  output logic              frame_start
);
  localparam logic [H_W-1:0] HBL_END = H_W'(HBLANK_LEN);
  localparam logic [H_W-1:0] HS_BEG  = H_W'(HSYNC_START);
  localparam logic [H_W-1:0] HS_END  = H_W'(HSYNC_START + HSYNC_LEN);
  localparam logic [V_W-1:0] VS_END  = V_W'(VSYNC_LINES);

  // reset: asserted asynchronously, released after SYNC_STAGES clocks
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [H_W-1:0] hcount_nxt;
  logic           line_end, frame_end, ilace;

  raster_hcount #(.CYC_50(CYC_50), .CYC_60(CYC_60), .H_W(H_W)) u_h (
    .clk(clk), .rst_n(rst_int_n), .cyc_en(cyc_en), .mode_60(mode_60),
    .hcount(hcount), .hcount_nxt(hcount_nxt), .line_end(line_end)
  );

  raster_vcount #(.LINES_50(LINES_50), .LINES_60(LINES_60), .V_W(V_W)) u_v (
    .clk(clk), .rst_n(rst_int_n), .line_end(line_end), .mode_60(mode_60),
    .ilace(ilace), .vcount(vcount), .frame_end(frame_end)
  );

  raster_regs #(.STEP_50(STEP_50), .STEP_60(STEP_60), .H_W(H_W), .V_W(V_W),
                .DATA_W(DATA_W)) u_r (
    .clk(clk), .rst_n(rst_int_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cyc_en(cyc_en), .mode_60(mode_60),
    .hcount_nxt(hcount_nxt), .vcount(vcount), .reg_rdata(reg_rdata),
    .ilace(ilace)
  );

  logic line_start_q, frame_start_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      line_start_q  <= 1'b0;
      frame_start_q <= 1'b0;
    end else begin
      line_start_q  <= line_end;
      frame_start_q <= frame_end;
    end
  end

  always_comb begin
    hblank      = hcount < HBL_END;
    hsync       = (hcount >= HS_BEG) && (hcount < HS_END);
    vsync       = vcount < VS_END;
    line_start  = line_start_q;
    frame_start = frame_start_q;
  end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
#(
  localparam int H_W = $clog2(max2(DEF_CYC_50, DEF_CYC_60)),
  localparam int V_W = $clog2(max2(DEF_LINES_50, DEF_LINES_60 + 1))
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cyc_en,
  input logic                  mode_60,
  input logic [1:0]            reg_addr,
  input logic [DEF_DATA_W-1:0] reg_rdata,
  input logic [H_W-1:0]        hcount,
  input logic [V_W-1:0]        vcount,
  input logic                  line_start,
  input logic                  frame_start
);
  localparam logic [H_W-1:0] L50 = H_W'(DEF_CYC_50 - 1);
  localparam logic [H_W-1:0] L60 = H_W'(DEF_CYC_60 - 1);
  localparam logic [H_W-1:0] S50 = H_W'(DEF_STEP_50);
  localparam logic [H_W-1:0] S60 = H_W'(DEF_STEP_60);
  localparam logic [V_W-1:0] VMAX60 = V_W'(DEF_LINES_60);

  p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !mode_60 && hcount == L50) |=> (hcount == '0 && line_start));

  p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && mode_60 && hcount == L60) |=> (hcount == '0 && line_start));

  p_frame_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (hcount == '0 && vcount == '0));

  p_frame_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_vbound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_60 |-> (vcount <= VMAX60));

  // R8 is covered by the 60 Hz arm of this property
  p_raster_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2 && $past(reg_addr) == 2'd2 && reg_rdata != $past(reg_rdata))
      |-> (hcount == (mode_60 ? S60 : S50)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> ($stable(hcount) && $stable(vcount) && !line_start && !frame_start));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .mode_60(mode_60),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .hcount(hcount),
  .vcount(vcount), .line_start(line_start), .frame_start(frame_start)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       mode_60 = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [6:0] hcount;
  logic [8:0] vcount;
  logic       hblank, hsync, vsync, line_start, frame_start;

  always #2.5ns clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .mode_60(mode_60),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hcount(hcount), .vcount(vcount),
    .hblank(hblank), .hsync(hsync), .vsync(vsync),
    .line_start(line_start), .frame_start(frame_start)
  );

  typedef struct {
    int hc; int vc; int vis; int ctl; int addr;
    bit ls; bit fs; bit en; bit m60; bit il;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  // reference model state
  int m_h, m_v, m_vis, m_ctl, m_tick;
  bit m_field;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)",
               tag, what, act, exp, m_h, m_v);
    end
  endtask

  // driver: applies one clock of stimulus and queues the expected result
  task automatic tick(bit en, bit we, logic [7:0] wd);
    int lh, lv, nh, nv, step;
    bit ls, fs, il;
    exp_t e;
    @(negedge clk);
    il   = m_ctl[7];
    lh   = mode_60 ? 64 : 70;
    lv   = mode_60 ? (260 + ((il && m_field) ? 1 : 0)) : 311;
    step = mode_60 ? 32 : 4;
    ls = 1'b0; fs = 1'b0; nh = m_h; nv = m_v;
    if (en) begin
      if (m_h >= lh) begin
        ls = 1'b1; nh = 0;
        if (m_v >= lv) begin
          fs = 1'b1; nv = 0; m_field = il ? ~m_field : 1'b0;
        end else nv = m_v + 1;
      end else nh = m_h + 1;
      if (nh == step) m_vis = m_v;
    end
    if (we) m_ctl = wd;
    m_h = nh; m_v = nv; m_tick++;
    cyc_en    = en;
    reg_we    = we;
    reg_wdata = wd;
    if (we) reg_addr = 2'd0;
    else if (nh == step || nh == step - 1) reg_addr = 2'd2;
    else reg_addr = 2'(m_tick % 3);
    e.hc = nh; e.vc = nv; e.vis = m_vis; e.ctl = m_ctl; e.addr = reg_addr;
    e.ls = ls; e.fs = fs; e.en = en; e.m60 = mode_60; e.il = il;
    q.push_back(e);
  endtask

  // monitor: compares each edge's outputs with the queued expectation
  always @(posedge clk) begin
    exp_t e;
    int   rd;
    string th, tv;
    #1ns;
    if (q.size() > 0) begin
      e  = q.pop_front();
      th = !e.en ? "R12" : (e.m60 ? "R3" : "R2");
      tv = !e.en ? "R12" : (e.m60 ? (e.il ? "R6" : "R5") : "R4");
      chk(hcount == 7'(e.hc), th, "hcount", int'(hcount), e.hc);
      chk(line_start == e.ls, th, "line_start", int'(line_start), int'(e.ls));
      chk(vcount == 9'(e.vc), tv, "vcount", int'(vcount), e.vc);
      chk(frame_start == e.fs, tv, "frame_start", int'(frame_start), int'(e.fs));
      chk(hblank == (e.hc < 12), "R11", "hblank", int'(hblank), int'(e.hc < 12));
      chk(hsync == (e.hc >= 2 && e.hc < 7), "R11", "hsync", int'(hsync),
          int'(e.hc >= 2 && e.hc < 7));
      chk(vsync == (e.vc < 3), "R11", "vsync", int'(vsync), int'(e.vc < 3));
      case (e.addr)
        0: chk(reg_rdata == 8'(e.ctl), "R10", "ctrl read", int'(reg_rdata), e.ctl);
        1: begin
          rd = (e.vis % 2) * 128;
          chk(reg_rdata == 8'(rd), "R9", "parity read", int'(reg_rdata), rd);
        end
        2: begin
          rd = e.vis / 2;
          chk(reg_rdata == 8'(rd), e.m60 ? "R8" : "R7", "raster read",
              int'(reg_rdata), rd);
        end
        default: ;
      endcase
    end
  end

  task automatic do_reset(bit m60);
    @(negedge clk);
    rst_n = 1'b0; cyc_en = 1'b0; reg_we = 1'b0; mode_60 = m60;
    m_h = 0; m_v = 0; m_vis = 0; m_ctl = 0; m_field = 1'b0; m_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(hcount == 7'd0, "R1", "hcount", int'(hcount), 0);
    chk(vcount == 9'd0, "R1", "vcount", int'(vcount), 0);
    chk(!line_start && !frame_start, "R1", "strobes",
        int'({line_start, frame_start}), 0);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a);
      #1ns;
      chk(reg_rdata == 8'd0, "R1", "register", int'(reg_rdata), 0);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 8'd0);
  endtask

  task automatic drain();
    @(negedge clk);
    cyc_en = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    // 50 Hz: gaps in the enable first (R12), then past a full frame (R2, R4, R7)
    do_reset(1'b0);
    for (int i = 0; i < 300; i++) tick((i % 5) != 3, 1'b0, 8'd0);
    run(312 * 71 + 150);
    // control register readback (R10), including with enable gaps
    tick(1'b0, 1'b1, 8'h5A);
    tick(1'b0, 1'b0, 8'd0);
    tick(1'b0, 1'b1, 8'h00);
    drain();

    // 60 Hz, interlace off (R3, R5, R8, R9)
    do_reset(1'b1);
    run(261 * 65 + 150);
    drain();

    // 60 Hz, interlace on: frames of 261 then 262 lines (R6)
    do_reset(1'b1);
    tick(1'b0, 1'b1, 8'h80);
    for (int i = 0; i < 200; i++) tick((i % 4) != 1, 1'b0, 8'd0);
    run(3 * 262 * 65);
    drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 5ns);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule